// File: doc/BRIEF.md
# Power Mode and Reset Flag Controller

This block holds the 8-bit power control register of a small processor core and runs the sequencing for three operating modes: normal run, idle and power-down. In idle it gates only the CPU clock enable and leaves the peripherals clocked. In power-down it gates both enables. When a wake event arrives in power-down, the block holds the internal core reset and keeps the clocks stopped for a start-up interval. That interval is either a fixed count of oscillator cycles or lasts until the external reset pin is released, chosen by a register bit.

The block tells a cold power-on reset apart from warm resets, which come from the reset pin or from the brown-out detector. A cold reset sets the power-off flag. Warm resets leave that flag as it is, so firmware can learn why it restarted. The two serial-port control bits in the register are driven straight out to the UART. One doubles the baud rate. The other selects whether the top bit of the serial control register shows a mode bit or the framing-error flag.

Top module: `pwrctl_top`

## Requirements
- R1: While `por_i` is high and on the first cycle after it, the register reads 8'h10 (only bit 4 set), `cpu_clk_en_o` and `periph_clk_en_o` are 1, and `core_rst_o` is 0.
- R2: Register bit positions: 7 = baud double (drives `baud_dbl_o`), 6 = frame-error view select (drives `fe_sel_o`), 5 = wake mode (1 external, 0 timed), 4 = power-off flag, 3..2 = general flags, 1 = power-down, 0 = idle. A write in run mode shows on `rd_data_o` one cycle later.
- R3: A warm reset (`pin_rst_i` or `bod_rst_i` high) clears every register bit except bit 4, which keeps its value. Software writes set or clear bit 4.
- R4: A run-mode write with bit 0 = 1 and bit 1 = 0 enters idle: `cpu_clk_en_o` = 0 and `periph_clk_en_o` = 1 from the next cycle.
- R5: In idle, `irq_i` high returns the block to run at the next clock edge. Bit 0 is cleared and all other bits are unchanged.
- R6: A run-mode write with bit 1 = 1 enters power-down, with both clock enables 0. When bits 1 and 0 are written together, power-down wins and bit 0 is stored as 0.
- R7: In power-down with bit 5 = 0, `irq_i` or a warm reset starts a timed wake. `core_rst_o` is 1 with both enables 0 for exactly STARTUP_CYC cycles, and then run resumes with bit 1 cleared.
- R8: In power-down with bit 5 = 1, a wake request holds `core_rst_o` at 1 until `pin_rst_i` has been sampled 1 and is then sampled 0. Run resumes at that same edge.
- R9: Register writes are ignored while the block is not in run mode.
- R10: Whenever `core_rst_o` is 1, both clock enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_i | input | 1 | Cold power-on reset, synchronous, active high |
| pin_rst_i | input | 1 | External reset pin, warm reset, active high |
| bod_rst_i | input | 1 | Brown-out warm reset, active high |
| irq_i | input | 1 | Any enabled interrupt pending |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register contents |
| baud_dbl_o | output | 1 | UART baud-rate doubling |
| fe_sel_o | output | 1 | UART top-bit view select (framing error vs mode) |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| core_rst_o | output | 1 | Internal core reset hold |

## Verification
Each register, enable and reset result is due one clock edge after the input that causes it. The bench drives inputs on the falling edge and samples half a period after the next rising edge. A timed wake is checked by counting, one sample per cycle, how long `core_rst_o` stays high after the wake edge; the count must equal STARTUP_CYC. An external wake is checked on the sample just after the pin's falling edge is clocked in, and ignored writes are checked by reading the register back after the block has returned to run.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;
  localparam int REG_W  = 8;
  localparam int B_BAUD = 7;
  localparam int B_FSEL = 6;
  localparam int B_XWK  = 5;
  localparam int B_POF  = 4;
  localparam int B_PD   = 1;
  localparam int B_IDL  = 0;
  localparam logic [REG_W-1:0] COLD_VAL = REG_W'(1) << B_POF;

  typedef enum logic [2:0] {
    ST_RUN, ST_IDLE, ST_PDOWN, ST_WAKE_TMR, ST_WAKE_EXT
  } pm_state_e;
endpackage

// File: rtl/pwrctl_reg.sv
module pwrctl_reg
  import pwrctl_pkg::*;
(
  input  logic             clk,
  input  logic             por_i,
  input  logic             warm_i,
  input  logic             wr_acc_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             clr_idl_i,
  input  logic             clr_pd_i,
  output logic [REG_W-1:0] ctl_q
);
  logic [REG_W-1:0] wr_val;

  always_comb begin
    wr_val = wr_data_i;
    if (wr_data_i[B_PD]) wr_val[B_IDL] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (por_i) begin
      ctl_q <= COLD_VAL;
    end else if (warm_i) begin
      ctl_q        <= '0;
      ctl_q[B_POF] <= ctl_q[B_POF];
    end else if (wr_acc_i) begin
      ctl_q <= wr_val;
    end else begin
      if (clr_idl_i) ctl_q[B_IDL] <= 1'b0;
      if (clr_pd_i)  ctl_q[B_PD]  <= 1'b0;
    end
  end
endmodule

// File: rtl/pwrctl_wake_timer.sv
module pwrctl_wake_timer #(
  parameter int STARTUP_CYC = 16
) (
  input  logic clk,
  input  logic por_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (STARTUP_CYC < 2) ? 1 : $clog2(STARTUP_CYC);
  localparam logic [CW-1:0] LAST = CW'(STARTUP_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (por_i || !run_i) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pwrctl_fsm.sv
module pwrctl_fsm
  import pwrctl_pkg::*;
(
  input  logic clk,
  input  logic por_i,
  input  logic warm_i,
  input  logic pin_rst_i,
  input  logic irq_i,
  input  logic wr_en_i,
  input  logic wr_pd_i,
  input  logic wr_idl_i,
  input  logic ext_mode_i,
  input  logic tmr_done_i,
  output logic wr_acc_o,
  output logic clr_idl_o,
  output logic clr_pd_o,
  output logic tmr_run_o,
  output logic cpu_en_o,
  output logic per_en_o,
  output logic core_rst_o
);
  pm_state_e st_q, st_d;
  logic      pin_prev_q;

  always_comb begin
    st_d      = st_q;
    clr_idl_o = 1'b0;
    clr_pd_o  = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (!warm_i && wr_en_i) begin
          if (wr_pd_i)       st_d = ST_PDOWN;
          else if (wr_idl_i) st_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (irq_i || warm_i) begin
          st_d      = ST_RUN;
          clr_idl_o = 1'b1;
        end
      end
      ST_PDOWN: begin
        if (irq_i || warm_i) st_d = ext_mode_i ? ST_WAKE_EXT : ST_WAKE_TMR;
      end
      ST_WAKE_TMR: begin
        if (tmr_done_i) begin
          st_d     = ST_RUN;
          clr_pd_o = 1'b1;
        end
      end
      ST_WAKE_EXT: begin
        if (pin_prev_q && !pin_rst_i) begin
          st_d     = ST_RUN;
          clr_pd_o = 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  assign wr_acc_o  = wr_en_i && !warm_i && (st_q == ST_RUN);
  assign tmr_run_o = (st_q == ST_WAKE_TMR);

  always_ff @(posedge clk) begin
    if (por_i) begin
      st_q       <= ST_RUN;
      pin_prev_q <= 1'b0;
      cpu_en_o   <= 1'b1;
      per_en_o   <= 1'b1;
      core_rst_o <= 1'b0;
    end else begin
      st_q       <= st_d;
      pin_prev_q <= pin_rst_i;
      cpu_en_o   <= (st_d == ST_RUN);
      per_en_o   <= (st_d == ST_RUN) || (st_d == ST_IDLE);
      core_rst_o <= (st_d == ST_WAKE_TMR) || (st_d == ST_WAKE_EXT);
    end
  end
endmodule

// File: rtl/pwrctl_top.sv
module pwrctl_top
  import pwrctl_pkg::*;
#(
  parameter int STARTUP_CYC = 16
) (
  input  logic             clk,
  input  logic             por_i,
  input  logic             pin_rst_i,
  input  logic             bod_rst_i,
  input  logic             irq_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             baud_dbl_o,
  output logic             fe_sel_o,
  output logic             cpu_clk_en_o,
  output logic             periph_clk_en_o,
  output logic             core_rst_o
);
  logic             warm;
  logic             wr_acc, clr_idl, clr_pd, tmr_run, tmr_done;
  logic [REG_W-1:0] ctl;

  assign warm = pin_rst_i || bod_rst_i;

  pwrctl_reg u_reg (
    .clk       (clk),
    .por_i     (por_i),
    .warm_i    (warm),
    .wr_acc_i  (wr_acc),
    .wr_data_i (wr_data_i),
    .clr_idl_i (clr_idl),
    .clr_pd_i  (clr_pd),
    .ctl_q     (ctl)
  );

  pwrctl_wake_timer #(.STARTUP_CYC(STARTUP_CYC)) u_tmr (
    .clk    (clk),
    .por_i  (por_i),
    .run_i  (tmr_run),
    .done_o (tmr_done)
  );

  pwrctl_fsm u_fsm (
    .clk        (clk),
    .por_i      (por_i),
    .warm_i     (warm),
    .pin_rst_i  (pin_rst_i),
    .irq_i      (irq_i),
    .wr_en_i    (wr_en_i),
    .wr_pd_i    (wr_data_i[B_PD]),
    .wr_idl_i   (wr_data_i[B_IDL]),
    .ext_mode_i (ctl[B_XWK]),
    .tmr_done_i (tmr_done),
    .wr_acc_o   (wr_acc),
    .clr_idl_o  (clr_idl),
    .clr_pd_o   (clr_pd),
    .tmr_run_o  (tmr_run),
    .cpu_en_o   (cpu_clk_en_o),
    .per_en_o   (periph_clk_en_o),
    .core_rst_o (core_rst_o)
  );

  assign rd_data_o  = ctl;
  assign baud_dbl_o = ctl[B_BAUD];
  assign fe_sel_o   = ctl[B_FSEL];
endmodule

// File: rtl/pwrctl_chk.sv
module pwrctl_chk (
  input logic       clk,
  input logic       por_i,
  input logic       pin_rst_i,
  input logic       bod_rst_i,
  input logic       irq_i,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       baud_dbl_o,
  input logic       fe_sel_o,
  input logic       cpu_clk_en_o,
  input logic       periph_clk_en_o,
  input logic       core_rst_o
);
  // R3: a warm reset never disturbs the power-off flag
  a_r3_pof_keeps: assert property (@(posedge clk) disable iff (por_i)
    (pin_rst_i || bod_rst_i) |=> rd_data_o[4] == $past(rd_data_o[4]));

  // R10: internal reset implies both clocks gated
  a_r10_rst_gates: assert property (@(posedge clk) disable iff (por_i)
    core_rst_o |-> (!cpu_clk_en_o && !periph_clk_en_o));

  // R6: power-down wins over idle and stores idle as 0
  a_r6_pd_wins: assert property (@(posedge clk) disable iff (por_i)
    (cpu_clk_en_o && wr_en_i && !pin_rst_i && !bod_rst_i && wr_data_i[1])
      |=> (!periph_clk_en_o && !rd_data_o[0]));

  // R9: writes while idle change nothing
  a_r9_idle_write: assert property (@(posedge clk) disable iff (por_i)
    (!cpu_clk_en_o && periph_clk_en_o && wr_en_i && !irq_i && !pin_rst_i && !bod_rst_i)
      |=> $stable(rd_data_o));

  // R7/R8: the end of a wake hold always lands in run mode
  a_r7_wake_to_run: assert property (@(posedge clk) disable iff (por_i)
    $fell(core_rst_o) |-> (cpu_clk_en_o && periph_clk_en_o));

  // R5: idle exits to run on an interrupt
  a_r5_idle_exit: assert property (@(posedge clk) disable iff (por_i)
    (!cpu_clk_en_o && periph_clk_en_o && irq_i) |=> cpu_clk_en_o);
endmodule

bind pwrctl_top pwrctl_chk chk_i (.*);

// File: tb/pwrctl_top_tb_top.sv
`timescale 1ns/1ps
module pwrctl_top_tb_top;
  localparam int NCYC = 16;

  logic       clk = 1'b0;
  logic       por_i = 1'b1, pin_rst_i = 1'b0, bod_rst_i = 1'b0, irq_i = 1'b0, wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       baud_dbl_o, fe_sel_o, cpu_clk_en_o, periph_clk_en_o, core_rst_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwrctl_top #(.STARTUP_CYC(NCYC)) dut_i (.*);

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // enables packed as {cpu, periph, core_rst}
  function automatic logic [7:0] en3();
    return {5'b0, cpu_clk_en_o, periph_clk_en_o, core_rst_o};
  endfunction

  localparam logic [7:0] M_RUN = 8'h6, M_IDLE = 8'h2, M_PD = 8'h0, M_WAKE = 8'h1;

  function automatic logic [7:0] after_wr(logic [7:0] d);
    return d[1] ? {d[7:1], 1'b0} : d;
  endfunction

  task automatic wr(logic [7:0] d);
    wr_en_i = 1; wr_data_i = d; tick(); wr_en_i = 0;
  endtask

  task automatic pulse_irq();
    irq_i = 1; tick(); irq_i = 0;
  endtask

  task automatic timed_wake(string tag, logic [7:0] exp_reg);
    int n = 0;
    while (core_rst_o && n < 1000) begin
      chk({tag, " hold gates"}, en3(), M_WAKE);
      n++; tick();
    end
    chk({tag, " hold length"}, 8'(n), 8'(NCYC));
    chk({tag, " run after"}, en3(), M_RUN);
    chk({tag, " reg after"}, rd_data_o, exp_reg);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    if (!done) $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h1357));
    @(negedge clk); tick();
    chk("R1 reg during por", rd_data_o, 8'h10);
    por_i = 0; tick();
    chk("R1 reg after por", rd_data_o, 8'h10);
    chk("R1 enables after por", en3(), M_RUN);

    // R2 layout and UART bits
    wr(8'hC0);
    chk("R2 readback", rd_data_o, 8'hC0);
    chk("R2 baud/fe", {6'b0, baud_dbl_o, fe_sel_o}, 8'h3);
    wr(8'h1C);
    chk("R3 pof set by sw", rd_data_o, 8'h1C);
    bod_rst_i = 1; tick(); bod_rst_i = 0;
    chk("R3 bod keeps pof", rd_data_o, 8'h10);
    wr(8'h0C);
    pin_rst_i = 1; tick(); pin_rst_i = 0;
    chk("R3 pin keeps cleared pof", rd_data_o, 8'h00);

    // R6 precedence, timed wake via brown-out
    wr(8'h13);
    chk("R6 pd wins reg", rd_data_o, 8'h12);
    chk("R6 pd gates", en3(), M_PD);
    wr(8'hFF);
    chk("R9 write in pd ignored", rd_data_o, 8'h12);
    bod_rst_i = 1; tick(); bod_rst_i = 0;
    timed_wake("R7 bod wake", 8'h10);

    // R8 external wake
    wr(8'h22);
    pulse_irq();
    for (int i = 0; i < 5; i++) begin
      chk("R8 held waiting for pin", en3(), M_WAKE);
      tick();
    end
    pin_rst_i = 1; tick();
    chk("R8 held while pin high", en3(), M_WAKE);
    chk("R3 pin clears reg", rd_data_o, 8'h00);
    pin_rst_i = 0; tick();
    chk("R8 run at pin release", en3(), M_RUN);

    // random mix
    for (int it = 0; it < 80; it++) begin
      d = 8'($urandom);
      wr(d);
      chk("R2 random readback", rd_data_o, after_wr(d));
      if (d[1]) begin
        chk("R6 random pd", en3(), M_PD);
        repeat (int'($urandom_range(0, 3))) tick();
        pulse_irq();
        if (d[5]) begin
          chk("R8 random hold", en3(), M_WAKE);
          pin_rst_i = 1; tick(); pin_rst_i = 0; tick();
          chk("R8 random release", en3(), M_RUN);
          chk("R3 random pin clear", rd_data_o, d & 8'h10);
        end else begin
          timed_wake("R7 random", d & 8'hFC);
        end
      end else if (d[0]) begin
        chk("R4 random idle", en3(), M_IDLE);
        wr(~d);
        chk("R9 idle write ignored", rd_data_o, d);
        pulse_irq();
        chk("R5 idle exit", en3(), M_RUN);
        chk("R5 idle bit cleared", rd_data_o, d & 8'hFE);
      end else begin
        chk("R2 random uart bits", {6'b0, baud_dbl_o, fe_sel_o}, {6'b0, d[7], d[6]});
        pulse_irq();
        chk("R2 irq in run no effect", rd_data_o, d);
        if (d[2]) begin
          bod_rst_i = 1; tick(); bod_rst_i = 0;
          chk("R3 random bod", rd_data_o, d & 8'h10);
        end
      end
    end

    por_i = 1; tick(); por_i = 0; tick();
    chk("R1 cold reset again", rd_data_o, 8'h10);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule